// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block holds the combinational hazard logic of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. For each of the two ALU operands of the instruction in execute, it picks where the operand value comes from. The choices are the register file, the execute/memory pipeline register (result of the instruction just ahead) or the memory/writeback pipeline register (result from two instructions ahead).

It also finds the case where a load in execute produces a register that the instruction in decode needs. In that case it holds the PC and the fetch/decode register for one cycle and squashes the decode/execute register into a bubble. A bubble writes no register and no memory.

When execute reports a taken branch or jump, the block flushes the fetch/decode register so that the PC can take the new target. It keeps no state: every output follows its inputs in the same cycle. A write-through register file covers the writeback-to-decode case, so no forwarding path from writeback to decode is produced.

Top module: `hazard_ctrl`

## Requirements
- R1: Each forward select is 2 bits wide and only ever takes 00 (register file), 01 (execute/memory register) or 10 (memory/writeback register), never 11. Operand A and operand B are selected independently.
- R2: A select reads 01 when the execute/memory instruction writes a register and its destination index is nonzero and equal to that operand's source index in execute.
- R3: A select reads 10 when the memory/writeback instruction writes a register and its destination index is nonzero and equal to the operand's source index, and R2 does not apply.
- R4: When both the execute/memory and memory/writeback destinations match an operand, the select reads 01.
- R5: A producer with destination index 0, or one that does not write a register, never causes forwarding, and the select stays 00.
- R6: When a load in execute writes a nonzero register that a used decode source reads, and no redirect is present, the PC hold, fetch/decode hold and decode/execute bubble outputs are all 1 in that cycle.
- R7: No stall is raised when the matching decode source is marked unused, when the execute instruction is not a load, when it writes no register, or when its destination index is 0.
- R8: A taken redirect from execute sets the fetch/decode flush to 1 and forces the three stall outputs to 0, overriding any load-use match.
- R9: With no redirect, the flush output is 0. With all inputs at 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source index of the decode instruction |
| id_rs2_i | input | REG_AW | Second source index of the decode instruction |
| id_use_rs1_i | input | 1 | Decode instruction reads its first source |
| id_use_rs2_i | input | 1 | Decode instruction reads its second source |
| ex_rs1_i | input | REG_AW | Operand A source index in execute |
| ex_rs2_i | input | REG_AW | Operand B source index in execute |
| ex_rd_i | input | REG_AW | Destination index in execute |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_redirect_i | input | 1 | Taken branch or jump resolved in execute |
| mem_rd_i | input | REG_AW | Destination index in memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | REG_AW | Destination index in writeback |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| pc_hold_o | output | 1 | Hold the PC |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_bubble_o | output | 1 | Load a bubble into the decode/execute register |
| ifid_flush_o | output | 1 | Flush the fetch/decode register |
| fwd_a_o | output | 2 | Operand A forward select |
| fwd_b_o | output | 2 | Operand B forward select |

## Verification
The embedded immediate assertions assume that every input is two-valued. An unknown index or enable would make them fail on what is only undriven stimulus. The bench therefore gives every driven signal a defined value at declaration and changes the inputs only on the falling clock edge. The small configuration uses a 2-bit register index, so the sweeps reach every coincidence of source and destination indices, including index 0, under every combination of write enables, load flag, use flags and redirect.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF   = 2'b00,
    FWD_EXM  = 2'b01,
    FWD_MWB  = 2'b10,
    FWD_RSVD = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exm_rd_i,
  input  logic              exm_wen_i,
  input  logic [REG_AW-1:0] mwb_rd_i,
  input  logic              mwb_wen_i,
  output fwd_sel_e          sel_o
);
  localparam logic [REG_AW-1:0] ZERO_IDX = '0;

  logic exm_hit, mwb_hit;

  assign exm_hit = exm_wen_i && (exm_rd_i != ZERO_IDX) && (exm_rd_i == src_i);
  assign mwb_hit = mwb_wen_i && (mwb_rd_i != ZERO_IDX) && (mwb_rd_i == src_i);

  // nearer producer wins
  always_comb begin
    if (exm_hit)      sel_o = FWD_EXM;
    else if (mwb_hit) sel_o = FWD_MWB;
    else              sel_o = FWD_RF;
  end

  always_comb begin
    p_sel_legal_r1: assert (sel_o != FWD_RSVD)
      else $error("reserved forward select");
    p_exm_src_r2: assert (sel_o != FWD_EXM || (exm_wen_i && exm_rd_i != ZERO_IDX))
      else $error("exm forward without a writing producer");
    p_mwb_src_r3: assert (sel_o != FWD_MWB || (mwb_wen_i && mwb_rd_i == src_i))
      else $error("mwb forward without matching producer");
    p_no_zero_r5: assert (src_i != ZERO_IDX || sel_o == FWD_RF)
      else $error("index 0 forwarded");
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned N_SRC  = 2
) (
  input  logic [N_SRC-1:0][REG_AW-1:0] id_src_i,
  input  logic [N_SRC-1:0]             id_use_i,
  input  logic [REG_AW-1:0]            ex_rd_i,
  input  logic                         ex_wen_i,
  input  logic                         ex_load_i,
  output logic                         hit_o
);
  localparam logic [REG_AW-1:0] ZERO_IDX = '0;

  logic             prod_live;
  logic [N_SRC-1:0] src_hit;

  assign prod_live = ex_load_i && ex_wen_i && (ex_rd_i != ZERO_IDX);

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign src_hit[s] = id_use_i[s] && (id_src_i[s] == ex_rd_i);
  end

  assign hit_o = prod_live && (|src_hit);

  always_comb begin
    p_stall_load_r7: assert (!hit_o || (ex_load_i && ex_wen_i))
      else $error("stall without writing load");
    p_stall_zero_r7: assert (!hit_o || ex_rd_i != ZERO_IDX)
      else $error("stall on index 0");
    p_stall_used_r7: assert (!hit_o || (|id_use_i))
      else $error("stall with no used source");
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic              ex_redirect_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o
);
  localparam int unsigned N_OPR = 2;

  logic [N_OPR-1:0][REG_AW-1:0] ex_src;
  logic [N_OPR-1:0][REG_AW-1:0] id_src;
  logic [N_OPR-1:0]             id_use;
  fwd_sel_e                     sel [N_OPR];
  logic                         lu_hit;
  logic                         stall;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};
  assign id_use = {id_use_rs2_i, id_use_rs1_i};

  for (genvar k = 0; k < N_OPR; k++) begin : g_opr
    hzd_fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_i     (ex_src[k]),
      .exm_rd_i  (mem_rd_i),
      .exm_wen_i (mem_wen_i),
      .mwb_rd_i  (wb_rd_i),
      .mwb_wen_i (wb_wen_i),
      .sel_o     (sel[k])
    );
  end

  hzd_load_use #(.REG_AW(REG_AW), .N_SRC(N_OPR)) u_lu (
    .id_src_i  (id_src),
    .id_use_i  (id_use),
    .ex_rd_i   (ex_rd_i),
    .ex_wen_i  (ex_wen_i),
    .ex_load_i (ex_load_i),
    .hit_o     (lu_hit)
  );

  // redirect wins: the held slot is wrong-path anyway
  assign stall         = lu_hit && !ex_redirect_i;
  assign pc_hold_o     = stall;
  assign ifid_hold_o   = stall;
  assign idex_bubble_o = stall;
  assign ifid_flush_o  = ex_redirect_i;
  assign fwd_a_o       = sel[0];
  assign fwd_b_o       = sel[1];

  always_comb begin
    p_flush_excl_r8: assert (!(ifid_flush_o && (pc_hold_o || idex_bubble_o)))
      else $error("flush together with stall");
    p_hold_pair_r6: assert (pc_hold_o == ifid_hold_o && ifid_hold_o == idex_bubble_o)
      else $error("stall outputs disagree");
    p_stall_src_r6: assert (!idex_bubble_o || lu_hit)
      else $error("bubble without load-use");
  end
endmodule

// File: tb/hazard_ctrl_bench.sv
module hazard_ctrl_bench;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic          id_use1 = 1'b0, id_use2 = 1'b0, ex_wen = 1'b0, ex_load = 1'b0;
  logic          redir = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic          pc_hold, ifid_hold, idex_bubble, ifid_flush;
  logic [1:0]    fwd_a, fwd_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) u_hazard_ctrl (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .id_use_rs1_i(id_use1), .id_use_rs2_i(id_use2),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_wen_i(ex_wen), .ex_load_i(ex_load), .ex_redirect_i(redir),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .idex_bubble_o(idex_bubble), .ifid_flush_o(ifid_flush),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b)
  );

  task automatic check(input int got, input int exp, input string req);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_fwd(input int src);
    bit h1, h2;
    h1 = mem_wen && mem_rd != 0 && int'(mem_rd) == src;
    h2 = wb_wen && wb_rd != 0 && int'(wb_rd) == src;
    if (h1) return 1;
    if (h2) return 2;
    return 0;
  endfunction

  function automatic string fwd_tag(input int src);
    bit m1, m2;
    m1 = mem_wen && mem_rd != 0 && int'(mem_rd) == src;
    m2 = wb_wen && wb_rd != 0 && int'(wb_rd) == src;
    if (m1 && m2) return "R4 both match";
    if (m1) return "R2 exm forward";
    if (m2) return "R3 mwb forward";
    if (int'(mem_rd) == src || int'(wb_rd) == src) return "R5 zero or no write";
    return "R1 register file";
  endfunction

  initial begin
    // R9: all-zero inputs give idle outputs
    @(negedge clk); #2;
    check(int'(pc_hold), 0, "R9 idle hold");
    check(int'(idex_bubble), 0, "R9 idle bubble");
    check(int'(ifid_flush), 0, "R9 idle flush");
    check(int'(fwd_a), 0, "R9 idle fwd a");
    check(int'(fwd_b), 0, "R9 idle fwd b");

    // forwarding sweep: R1..R5
    for (int v = 0; v < 1024; v++) begin
      @(negedge clk);
      ex_rs1  = v[1:0];
      ex_rs2  = v[3:2];
      mem_rd  = v[5:4];
      mem_wen = v[6];
      wb_rd   = v[8:7];
      wb_wen  = v[9];
      #2;
      check(int'(fwd_a), exp_fwd(int'(ex_rs1)), {fwd_tag(int'(ex_rs1)), " (A)"});
      check(int'(fwd_b), exp_fwd(int'(ex_rs2)), {fwd_tag(int'(ex_rs2)), " (B)"});
      check(int'(pc_hold), 0, "R7 no load, no hold");
      check(int'(ifid_flush), 0, "R9 no redirect, no flush");
    end
    mem_wen = 1'b0; wb_wen = 1'b0;

    // load-use and redirect sweep: R6..R9
    for (int v = 0; v < 2048; v++) begin
      bit lu, st;
      @(negedge clk);
      id_rs1  = v[1:0];
      id_rs2  = v[3:2];
      id_use1 = v[4];
      id_use2 = v[5];
      ex_rd   = v[7:6];
      ex_wen  = v[8];
      ex_load = v[9];
      redir   = v[10];
      #2;
      lu = ex_load && ex_wen && ex_rd != 0 &&
           ((id_use1 && id_rs1 == ex_rd) || (id_use2 && id_rs2 == ex_rd));
      st = lu && !redir;
      if (redir) begin
        check(int'(ifid_flush), 1, "R8 redirect flush");
        check(int'(pc_hold), 0, "R8 redirect overrides pc hold");
        check(int'(idex_bubble), 0, "R8 redirect overrides bubble");
      end else if (lu) begin
        check(int'(ifid_flush), 0, "R9 no flush");
        check(int'(pc_hold), 1, "R6 pc hold");
        check(int'(ifid_hold), 1, "R6 ifid hold");
        check(int'(idex_bubble), 1, "R6 bubble");
      end else begin
        check(int'(ifid_flush), 0, "R9 no flush");
        check(int'(pc_hold), int'(st), "R7 no stall pc");
        check(int'(ifid_hold), int'(st), "R7 no stall ifid");
        check(int'(idex_bubble), int'(st), "R7 no stall bubble");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule